// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a parallel NOR flash bus. The bus is asynchronous: an address, a data bus with separate in and out halves, and active-low chip enable, output enable and write enable. The block runs from the system clock. A requester hands it one operation at a time: program one word, erase a sector, erase a block or erase the whole chip. The block drives the unlock write sequence for that operation with clock-counted strobe widths. It then reads the device repeatedly and watches status bit 6, which flips on every read while the device is busy.

The block does not trust the first pair of matching status reads. It declares the operation finished only after a run of matching reads. It then keeps the bus quiet for a recovery interval and reports the result. If the device is still busy when the time limit for the operation class runs out, the block ends the operation with an error flag and issues nothing further. All widths and strobe times are counted in clock cycles and set by parameters.

The request side is a valid/ready port. `req_ready` is high only while the block is idle. A request is taken on the clock edge where both `req_valid` and `req_ready` are high. While the block is busy it exerts back-pressure by holding `req_ready` low. A requester may hold `req_valid` and its fields for any length of time. Nothing is taken until the block returns to idle.

Top module: `flash_pe_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle, and a request is taken only on a clock edge where both `req_valid` and `req_ready` are high. `busy_o` rises the cycle after a request is taken and stays high until `done_o`. A request presented while busy is ignored: it changes neither the writes issued nor the result.
- R2: A program request (op code 0) issues exactly 4 write cycles, as (address, data) pairs: (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0), (request address, request data). Unlock addresses are zero-extended to the address width and unlock data to the data width.
- R3: An erase request issues exactly 6 write cycles: (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), followed by a last write that depends on the op code. Sector erase (op 1) ends with (request address, 0x30). Block erase (op 2) ends with (request address, 0x50). Chip erase (op 3) ends with (0x5555, 0x10).
- R4: Each write cycle holds `fl_we_n` low for at least WE_LOW_CYC cycles. The address and data stay stable, with `fl_dq_oe` high, for the whole low phase. `fl_we_n` then stays high for at least WE_HIGH_CYC cycles before the next write.
- R5: Each status read holds `fl_oe_n` low for at least RD_CYC cycles and samples at the end of that window. `fl_dq_oe` and `fl_we_n` are inactive during the read. `fl_oe_n` falls only after `fl_we_n` has been high for at least OE_HOLD_CYC cycles, and only after `fl_oe_n` itself has been high for at least OE_HOLD_CYC cycles.
- R6: Completion needs four consecutive status reads with equal bit 6: one matching pair to detect the stop, then two confirming reads. A matching pair that is followed by a differing read does not complete the operation.
- R7: After completion is confirmed, `fl_oe_n` and `fl_we_n` stay high for RECOV_CYC cycles before `done_o` pulses with `err_o` low.
- R8: The limit in polling cycles is TMO_PROG for a program, TMO_SB for a sector or block erase and TMO_CHIP for a chip erase. When a read ends at or past the limit without completion, `done_o` pulses with `err_o` high. This happens no earlier than the limit after the last write, and no write follows it.
- R9: During and right after reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, `fl_dq_oe`, `busy_o`, `done_o` and `err_o` are low, and `req_ready` is high.
- R10: `done_o` is a one-cycle pulse. `err_o` keeps its value until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Word address, or sector/block address |
| req_wdata | input | DW | Word to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Last operation timed out |
| fl_addr | output | AW | Flash address bus |
| fl_dq_o | output | DW | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for write data |
| fl_dq_i | input | DW | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The hardest state to reach from the ports is a false stop. In that state two status reads agree while the device is still busy, and the next read flips again. A ready-made flash model never produces this. The bench's own device model therefore repeats one toggle value on chosen reads while it is busy. A design that completes on the first matching pair then finishes before the model's busy time ends. The timeout path is reached by a model that never stops toggling, both under the short program limit and under the long chip limit.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } fpe_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WR   = 2'd1,
    S_POLL = 2'd2,
    S_REC  = 2'd3
  } fpe_state_e;

  localparam logic [14:0] UNLK_A = 15'h5555;
  localparam logic [14:0] UNLK_B = 15'h2AAA;
  localparam logic [7:0]  CD_AA  = 8'hAA;
  localparam logic [7:0]  CD_55  = 8'h55;
  localparam logic [7:0]  CD_PGM = 8'hA0;
  localparam logic [7:0]  CD_ERS = 8'h80;
  localparam logic [7:0]  CD_SEC = 8'h30;
  localparam logic [7:0]  CD_BLK = 8'h50;
  localparam logic [7:0]  CD_CHP = 8'h10;
  localparam int          STATUS_BIT = 6;
endpackage

// File: rtl/fpe_bus_cycle.sv
module fpe_bus_cycle #(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int WE_LOW_CYC  = 10,
  parameter int WE_HIGH_CYC = 8,
  parameter int OE_HOLD_CYC = 3,
  parameter int RD_CYC      = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  input  logic [DW-1:0] dq_i
);
  localparam int M1 = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int M2 = (OE_HOLD_CYC > RD_CYC) ? OE_HOLD_CYC : RD_CYC;
  localparam int MX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MX + 1);

  typedef enum logic [2:0] {B_IDLE, B_WLO, B_WHI, B_RGAP, B_RLO} bst_e;
  bst_e          st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= B_IDLE;
      cnt     <= '0;
      done_o  <= 1'b0;
      addr_o  <= '0;
      dq_o    <= '0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          addr_o <= addr_i;
          dq_o   <= wdata_i;
          cnt    <= '0;
          st     <= is_wr ? B_WLO : B_RGAP;
        end
        B_WLO: if (cnt == CW'(WE_LOW_CYC - 1)) begin
          cnt <= '0;
          st  <= B_WHI;
        end else cnt <= cnt + 1'b1;
        B_WHI: if (cnt == CW'(WE_HIGH_CYC - 1)) begin
          st     <= B_IDLE;
          done_o <= 1'b1;
        end else cnt <= cnt + 1'b1;
        B_RGAP: if (cnt == CW'(OE_HOLD_CYC - 1)) begin
          cnt <= '0;
          st  <= B_RLO;
        end else cnt <= cnt + 1'b1;
        B_RLO: if (cnt == CW'(RD_CYC - 1)) begin
          rdata_o <= dq_i;
          st      <= B_IDLE;
          done_o  <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= B_IDLE;
      endcase
    end
  end

  assign idle_o  = (st == B_IDLE);
  assign we_n_o  = (st != B_WLO);
  assign oe_n_o  = (st != B_RLO);
  assign dq_oe_o = (st == B_WLO) || (st == B_WHI);

  // Run-length counters watched by the checks below.
  logic [CW:0] lo_run, hi_run, oe_hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run    <= '0;
      hi_run    <= (CW+1)'(MX);
      oe_hi_run <= (CW+1)'(MX);
    end else begin
      lo_run    <= !we_n_o ? lo_run + 1'b1 : '0;
      hi_run    <= !we_n_o ? '0 : ((hi_run < (CW+1)'(MX)) ? hi_run + 1'b1 : hi_run);
      oe_hi_run <= !oe_n_o ? '0 : ((oe_hi_run < (CW+1)'(MX)) ? oe_hi_run + 1'b1 : oe_hi_run);
    end
  end

  // R4
  we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> lo_run >= (CW+1)'(WE_LOW_CYC));
  // R4
  wr_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o && $past(!we_n_o)) |-> ($stable(addr_o) && $stable(dq_o) && dq_oe_o));
  // R5
  oe_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n_o) |-> (hi_run >= (CW+1)'(OE_HOLD_CYC) && oe_hi_run >= (CW+1)'(OE_HOLD_CYC)));
  // R5
  no_strobe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n_o && !we_n_o));
endmodule

// File: rtl/fpe_toggle_judge.sv
module fpe_toggle_judge #(
  parameter int CONFIRM_READS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic smp_valid,
  input  logic smp_bit,
  output logic settled_o
);
  localparam int NEED = CONFIRM_READS - 1;
  localparam int SW   = $clog2(CONFIRM_READS + 1);

  logic          have_prev, prev;
  logic [SW-1:0] run;
  logic          same;

  assign same      = have_prev && (smp_bit == prev);
  assign settled_o = smp_valid && same && (run == SW'(NEED - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev      <= 1'b0;
      run       <= '0;
    end else if (clear) begin
      have_prev <= 1'b0;
      run       <= '0;
    end else if (smp_valid) begin
      have_prev <= 1'b1;
      prev      <= smp_bit;
      run       <= same ? run + 1'b1 : '0;
    end
  end

  // R6
  settle_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled_o |-> (have_prev && !clear));
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import fpe_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int WE_LOW_CYC  = 10,
  parameter int WE_HIGH_CYC = 8,
  parameter int OE_HOLD_CYC = 3,
  parameter int RD_CYC      = 20,
  parameter int RECOV_CYC   = 250,
  parameter int TMO_PROG    = 5000,
  parameter int TMO_SB      = 6250000,
  parameter int TMO_CHIP    = 25000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int TM1 = (TMO_SB > TMO_PROG) ? TMO_SB : TMO_PROG;
  localparam int TMX = (TMO_CHIP > TM1) ? TMO_CHIP : TM1;
  localparam int TW  = $clog2(TMX + 1);
  localparam int RW  = $clog2(RECOV_CYC + 1);

  fpe_state_e    st;
  fpe_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    idx;
  logic [TW-1:0] tmo_cnt, tmo_lim;
  logic [RW-1:0] rec_cnt;
  logic [2:0]    seq_last;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_data;
  logic          bus_idle, bus_done, bus_start, settled;
  logic [DW-1:0] bus_rdata;
  logic          accept;

  assign accept    = req_valid && req_ready;
  assign req_ready = (st == S_IDLE);
  assign busy_o    = (st != S_IDLE);
  assign fl_ce_n   = (st == S_IDLE);
  assign bus_start = ((st == S_WR) || (st == S_POLL)) && bus_idle && !bus_done;
  assign seq_last  = (op_q == OP_PROG) ? 3'd3 : 3'd5;

  always_comb begin
    case (op_q)
      OP_PROG: tmo_lim = TW'(TMO_PROG);
      OP_CHIP: tmo_lim = TW'(TMO_CHIP);
      default: tmo_lim = TW'(TMO_SB);
    endcase
  end

  // Unlock sequence: index picks the (address, data) pair of each write.
  function automatic logic [AW-1:0] ua(input logic [14:0] a);
    return AW'(a);
  endfunction
  function automatic logic [DW-1:0] ud(input logic [7:0] d);
    return DW'(d);
  endfunction

  always_comb begin
    seq_addr = ua(UNLK_A);
    seq_data = ud(CD_AA);
    case (idx)
      3'd1, 3'd4: begin seq_addr = ua(UNLK_B); seq_data = ud(CD_55); end
      3'd2: seq_data = ud((op_q == OP_PROG) ? CD_PGM : CD_ERS);
      3'd3: if (op_q == OP_PROG) begin
        seq_addr = addr_q;
        seq_data = data_q;
      end
      3'd5: case (op_q)
        OP_SECTOR: begin seq_addr = addr_q; seq_data = ud(CD_SEC); end
        OP_BLOCK:  begin seq_addr = addr_q; seq_data = ud(CD_BLK); end
        default:   seq_data = ud(CD_CHP);
      endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      idx     <= '0;
      tmo_cnt <= '0;
      rec_cnt <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= fpe_op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_wdata;
          idx    <= '0;
          err_o  <= 1'b0;
          st     <= S_WR;
        end
        S_WR: if (bus_done) begin
          if (idx == seq_last) begin
            tmo_cnt <= '0;
            st      <= S_POLL;
          end else idx <= idx + 1'b1;
        end
        S_POLL: begin
          if (tmo_cnt < tmo_lim) tmo_cnt <= tmo_cnt + 1'b1;
          if (bus_done) begin
            if (settled) begin
              rec_cnt <= '0;
              st      <= S_REC;
            end else if (tmo_cnt >= tmo_lim) begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
              st     <= S_IDLE;
            end
          end
        end
        S_REC: if (rec_cnt == RW'(RECOV_CYC - 1)) begin
          done_o <= 1'b1;
          st     <= S_IDLE;
        end else rec_cnt <= rec_cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  fpe_bus_cycle #(
    .AW(AW), .DW(DW), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
    .OE_HOLD_CYC(OE_HOLD_CYC), .RD_CYC(RD_CYC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .is_wr(st == S_WR),
    .addr_i(seq_addr), .wdata_i(seq_data), .idle_o(bus_idle), .done_o(bus_done),
    .rdata_o(bus_rdata), .addr_o(fl_addr), .dq_o(fl_dq_o), .dq_oe_o(fl_dq_oe),
    .we_n_o(fl_we_n), .oe_n_o(fl_oe_n), .dq_i(fl_dq_i)
  );

  fpe_toggle_judge #(.CONFIRM_READS(4)) u_judge (
    .clk(clk), .rst_n(rst_n), .clear(st != S_POLL),
    .smp_valid(bus_done && (st == S_POLL)), .smp_bit(bus_rdata[STATUS_BIT]),
    .settled_o(settled)
  );

  logic unused_rd;
  assign unused_rd = ^bus_rdata;

  // Write strobes seen on the pin during the current operation.
  logic       we_prev;
  logic [3:0] wr_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev <= 1'b1;
      wr_seen <= '0;
    end else begin
      we_prev <= fl_we_n;
      if (accept) wr_seen <= '0;
      else if (fl_we_n && !we_prev) wr_seen <= wr_seen + 1'b1;
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2 R3
  wr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (wr_seen == ((op_q == OP_PROG) ? 4'd4 : 4'd6)));
  // R8
  poll_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL || st == S_REC) |-> (fl_we_n && !fl_dq_oe));
  // R7
  rec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REC) |-> (fl_oe_n && fl_we_n));
endmodule

// File: tb/tb_flash_pe_seq.sv
module tb_flash_pe_seq;
  localparam int AW = 20, DW = 16;
  localparam int WE_LOW = 4, WE_HIGH = 3, OE_HOLD = 2, RD = 6, RECOV = 40;
  localparam int T_PROG = 300, T_SB = 600, T_CHIP = 900;
  localparam int PERIOD = 10;
  localparam logic [15:0] FINAL = 16'h1234;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy_o, done_o, err_o, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o;
  logic [DW-1:0] fl_dq_i = '0;

  always #2 clk = ~clk;

  flash_pe_seq #(.AW(AW), .DW(DW), .WE_LOW_CYC(WE_LOW), .WE_HIGH_CYC(WE_HIGH),
    .OE_HOLD_CYC(OE_HOLD), .RD_CYC(RD), .RECOV_CYC(RECOV),
    .TMO_PROG(T_PROG), .TMO_SB(T_SB), .TMO_CHIP(T_CHIP)) dut (.*);

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Bench monitor and device model
  longint cyc = 0, last_rise = 0, last_oe_rise = 0, done_cyc = 0, busy_until = 64'h7fffffff;
  int t_end_cur = 0, rd_k = 0, nwr = 0, lo_run = 0, hi_run = 100, oe_hi = 100, oe_lo = 0;
  bit prev_we = 1, prev_oe = 1, tbad = 0, fake = 0, done_seen = 0, done_err = 0, model_t = 0;
  logic [AW-1:0] wa, log_a[8];
  logic [DW-1:0] wd, log_d[8];

  always @(negedge clk) begin
    cyc++;
    if (!fl_we_n) begin
      if (prev_we) begin
        if (nwr > 0 && hi_run < WE_HIGH) tbad = 1;
        lo_run = 1; wa = fl_addr; wd = fl_dq_o;
      end else lo_run++;
      if (fl_addr !== wa || fl_dq_o !== wd || !fl_dq_oe || !fl_oe_n) tbad = 1;
      hi_run = 0;
    end else begin
      if (!prev_we) begin
        if (lo_run < WE_LOW) tbad = 1;
        if (nwr < 8) begin log_a[nwr] = wa; log_d[nwr] = wd; end
        nwr++; last_rise = cyc; busy_until = cyc + t_end_cur; rd_k = 0;
      end
      hi_run++;
    end
    if (!fl_oe_n) begin
      if (prev_oe) begin
        if (hi_run < OE_HOLD || oe_hi < OE_HOLD) tbad = 1;
        oe_lo = 0;
        if (cyc < busy_until) begin
          if (!(fake && rd_k == 2)) model_t = ~model_t;
          rd_k++;
          fl_dq_i = {9'h0, model_t, 6'h0};
        end else fl_dq_i = FINAL;
      end
      oe_lo++; oe_hi = 0;
      if (fl_dq_oe) tbad = 1;
    end else begin
      if (!prev_oe) begin
        if (oe_lo < RD) tbad = 1;
        last_oe_rise = cyc;
      end
      oe_hi++;
    end
    if (done_o && !done_seen) begin done_seen = 1; done_cyc = cyc; done_err = err_o; end
    prev_we = fl_we_n; prev_oe = fl_oe_n;
  end

  function automatic int exp_len(input logic [1:0] op);
    return (op == 2'd0) ? 4 : 6;
  endfunction
  function automatic int exp_lim(input logic [1:0] op);
    return (op == 2'd0) ? T_PROG : (op == 2'd3) ? T_CHIP : T_SB;
  endfunction
  function automatic logic [AW-1:0] exp_a(input logic [1:0] op, input int i, input logic [AW-1:0] a);
    if (i == 1 || i == 4) return AW'(15'h2AAA);
    if ((op == 2'd0 && i == 3) || (i == 5 && op != 2'd3)) return a;
    return AW'(15'h5555);
  endfunction
  function automatic logic [DW-1:0] exp_d(input logic [1:0] op, input int i, input logic [DW-1:0] d);
    case (i)
      0, 3: return (op == 2'd0 && i == 3) ? d : 16'h00AA;
      1, 4: return 16'h0055;
      2: return (op == 2'd0) ? 16'h00A0 : 16'h0080;
      default: return (op == 2'd1) ? 16'h0030 : (op == 2'd2) ? 16'h0050 : 16'h0010;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int t_end, input bit fk, input bit exp_tmo, input bit poke);
    int w;
    string rq;
    nwr = 0; tbad = 0; done_seen = 0; fake = fk; t_end_cur = t_end;
    busy_until = 64'h7fffffff;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_op = 2'(~op); req_addr = ~a; req_wdata = ~d;
    chk(busy_o && !req_ready, "R1 busy after accept", busy_o, 1);
    if (poke) begin
      repeat (15) @(negedge clk);
      req_valid = 1; req_op = 2'd3;
      repeat (5) begin @(negedge clk); chk(!req_ready, "R1 ready low while busy", req_ready, 0); end
      req_valid = 0;
    end
    w = 0;
    while (!done_seen && w < 20000) begin @(negedge clk); w++; end
    chk(done_seen, "R1 done reached", done_seen, 1);
    rq = (op == 2'd0) ? "R2 write sequence" : "R3 write sequence";
    chk(nwr == exp_len(op), {rq, " count"}, nwr, exp_len(op));
    for (int i = 0; i < exp_len(op) && i < nwr; i++) begin
      chk(log_a[i] == exp_a(op, i, a), {rq, " addr"}, log_a[i], exp_a(op, i, a));
      chk(log_d[i] == exp_d(op, i, d), {rq, " data"}, log_d[i], exp_d(op, i, d));
    end
    chk(!tbad, "R4 R5 strobe timing", tbad, 0);
    if (exp_tmo) begin
      chk(done_err == 1, "R8 timeout flag", done_err, 1);
      chk(done_cyc - last_rise >= exp_lim(op) && done_cyc - last_rise <= exp_lim(op) + PERIOD + 6,
          "R8 timeout window", done_cyc - last_rise, exp_lim(op));
    end else begin
      chk(done_err == 0, "R6 no error", done_err, 0);
      chk(done_cyc - last_rise >= t_end + RECOV &&
          done_cyc - last_rise <= t_end + RECOV + 5 * PERIOD + 6,
          "R6 completion after busy end", done_cyc - last_rise, t_end + RECOV);
      chk(done_cyc - last_oe_rise >= RECOV && done_cyc - last_oe_rise <= RECOV + 4,
          "R7 recovery gap", done_cyc - last_oe_rise, RECOV);
    end
    chk(!busy_o && req_ready, "R1 idle after done", busy_o, 0);
    @(negedge clk);
    chk(!done_o, "R10 done one cycle", done_o, 0);
    repeat (3) @(negedge clk);
    chk(err_o == exp_tmo, "R10 err held", err_o, exp_tmo);
    chk(nwr == exp_len(op), "R8 no write after end", nwr, exp_len(op));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R9 bus idle in reset",
        {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    chk(!busy_o && !done_o && !err_o, "R9 status in reset", {busy_o, done_o, err_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && fl_ce_n, "R9 ready after reset", req_ready, 1);
    // directed corner cases
    run_op(2'd0, 20'hABCDE, 16'hBEEF, 30, 0, 0, 0);
    run_op(2'd0, 20'h00010, 16'h1111, 150, 1, 0, 0);   // R6 false stop
    run_op(2'd1, 20'h7FC00, 16'h0, 200, 1, 0, 0);       // R6 false stop on erase
    run_op(2'd0, 20'h12345, 16'h5A5A, 100, 0, 0, 1);    // R1 request while busy
    run_op(2'd0, 20'h00001, 16'h0001, 1000000, 0, 1, 0); // R8 program timeout
    run_op(2'd3, 20'h0, 16'h0, 1000000, 0, 1, 0);        // R8 chip timeout
    run_op(2'd2, 20'hF8000, 16'h0, 10, 0, 0, 0);
    // random
    for (int n = 0; n < 20; n++) begin
      logic [1:0] op;
      int te;
      op = 2'($urandom % 4);
      te = 5 + ((op == 2'd0) ? $urandom % 150 : (op == 2'd3) ? $urandom % 600 : $urandom % 400);
      run_op(op, AW'($urandom), DW'($urandom), te, ($urandom % 3) == 0, 0, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule